// File: doc/BRIEF.md
# Audio Sample Alignment and Packing Unit

This block converts audio samples between a 32-bit memory-side word stream and the per-slot stream of a serial audio port. It works in both directions at once. The playback path takes memory words and delivers one 32-bit slot container per sample. The capture path takes slot containers and delivers memory words. Every stream edge uses a valid/ready handshake and honours backpressure.

Three static inputs set the conversion. The sample width can be 8, 16, 18, 20, 24 or 32 bits. The sample can be placed at the top or at the bottom of its container. The memory side can be unpacked, with one sample per word, or packed, where samples run back to back and may straddle word boundaries. Settings may change only while the unit is idle. A synchronous clear empties both paths, and in packed capture a flush pulse pushes out a trailing partial word.

Top module: `audio_align_pack`

## Requirements
- R1: The width code on width_sel_i selects the sample width w as follows: 0 gives 8, 1 gives 16, 2 gives 18, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32. In unpacked playback, each memory word supplies one sample taken from its low w bits, and its upper bits are ignored.
- R2: When right_just_i=1, a slot carries the sample in its low w bits, and the remaining upper bits are copies of sample bit w-1.
- R3: When right_just_i=0, a slot carries the sample in its top w bits, and its low 32-w bits are zero.
- R4: In packed playback (packed_i=1), the memory words form one continuous bit stream, least significant bit first. Each slot takes the next w bits of that stream, even when those bits span two words.
- R5: Capture extracts the sample from the low w bits of the container when right-justified, or from the top w bits when left-justified. In unpacked capture, each sample becomes one memory word, sign-extended from bit w-1.
- R6: In packed capture, samples are appended to the bit stream least significant bit first. A memory word is emitted each time 32 bits have been gathered, so a sample may be split across two words.
- R7: A one-cycle pulse on flush_i makes the capture path emit, after any complete words, the fewer than 32 bits that remain as one final word with its unused upper bits zero. If nothing is held, no word is emitted.
- R8: With valid and ready held high on every side, after at most 6 cycles of fill, playback presents a slot on every cycle and capture accepts a slot on every cycle.
- R9: Under arbitrary stalls, every sample is delivered exactly once and in order. An output that is stalled keeps valid high and its data unchanged.
- R10: After reset, and in the cycle after clear_i, both buffers are empty: no output is valid, both inputs are ready, and later data starts from an empty bit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of both paths |
| width_sel_i | input | 3 | Sample width code |
| right_just_i | input | 1 | 1: sample at the bottom of the slot, 0: at the top |
| packed_i | input | 1 | 1: packed memory layout, 0: one sample per word |
| flush_i | input | 1 | Emit the trailing partial capture word |
| pb_mem_data_i | input | 32 | Playback memory word |
| pb_mem_valid_i | input | 1 | Playback memory word valid |
| pb_mem_ready_o | output | 1 | Playback memory word accepted |
| pb_slot_data_o | output | 32 | Playback slot container |
| pb_slot_valid_o | output | 1 | Playback slot valid |
| pb_slot_ready_i | input | 1 | Serial side takes the slot |
| cap_slot_data_i | input | 32 | Captured slot container |
| cap_slot_valid_i | input | 1 | Captured slot valid |
| cap_slot_ready_o | output | 1 | Captured slot accepted |
| cap_mem_data_o | output | 32 | Capture memory word |
| cap_mem_valid_o | output | 1 | Capture memory word valid |
| cap_mem_ready_i | input | 1 | Memory side takes the word |

## Verification
A bit count or shift offset that is off corrupts every later sample. The fault shows on the first slot or memory word after the error, as a rotated or misaligned value, and a bit-level model of both streams flags it. A lost or duplicated handshake leaves the model's bit stream out of step, and this shows within one sample; it also shows at the end of a run, when bits are left over or missing after the drain. A flush that never finishes leaves capture bits stranded, and these are caught when the queue fails to empty.

// File: rtl/apu_pkg.sv
package apu_pkg;
  localparam int SLOT_W = 32;
  localparam int WID_W  = $clog2(SLOT_W + 1);

  typedef logic [WID_W-1:0]  wid_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [2:0] {
    SW_8  = 3'd0,
    SW_16 = 3'd1,
    SW_18 = 3'd2,
    SW_20 = 3'd3,
    SW_24 = 3'd4,
    SW_32 = 3'd5
  } width_sel_e;

  function automatic wid_t width_bits(logic [2:0] sel);
    case (width_sel_e'(sel))
      SW_8:    return wid_t'(8);
      SW_16:   return wid_t'(16);
      SW_18:   return wid_t'(18);
      SW_20:   return wid_t'(20);
      SW_24:   return wid_t'(24);
      default: return wid_t'(SLOT_W);
    endcase
  endfunction

  function automatic slot_t low_mask(wid_t w);
    if (w >= wid_t'(SLOT_W)) return '1;
    return (slot_t'(1) << w) - slot_t'(1);
  endfunction

  // s must be clean above bit w-1
  function automatic slot_t align_slot(slot_t s, wid_t w, logic right);
    slot_t m;
    m = low_mask(w);
    if (right) return s[w - wid_t'(1)] ? (s | ~m) : (s & m);
    return s << (wid_t'(SLOT_W) - w);
  endfunction

  function automatic slot_t extract_sample(slot_t c, wid_t w, logic right);
    if (right) return c & low_mask(w);
    return c >> (wid_t'(SLOT_W) - w);
  endfunction
endpackage

// File: rtl/apu_bitbuf.sv
module apu_bitbuf #(
  parameter  int DATA_W = 32,
  parameter  int BUF_W  = 3 * DATA_W,
  localparam int CNT_W  = $clog2(BUF_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [CNT_W-1:0]  push_len_i,
  input  logic              pop_i,
  input  logic [CNT_W-1:0]  pop_len_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  level_o
);
  logic [BUF_W-1:0] bits_q, bits_d, shifted;
  logic [CNT_W-1:0] level_q, level_d, lvl_mid;

  // pop from the bottom first, then append above what remains
  always_comb begin
    shifted = pop_i ? (bits_q >> pop_len_i) : bits_q;
    lvl_mid = pop_i ? (level_q - pop_len_i) : level_q;
    bits_d  = shifted;
    level_d = lvl_mid;
    if (push_i) begin
      bits_d  = shifted | (BUF_W'(push_data_i) << lvl_mid);
      level_d = lvl_mid + push_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q  <= '0;
      level_q <= '0;
    end else if (clear_i) begin
      bits_q  <= '0;
      level_q <= '0;
    end else begin
      bits_q  <= bits_d;
      level_q <= level_d;
    end
  end

  assign head_o  = bits_q[DATA_W-1:0];
  assign level_o = level_q;
endmodule

// File: rtl/apu_playback.sv
module apu_playback
  import apu_pkg::*;
#(
  parameter  int BUF_W = 3 * SLOT_W,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  wid_t             w_i,
  input  logic             right_i,
  input  logic             packed_i,
  input  slot_t            mem_data_i,
  input  logic             mem_valid_i,
  output logic             mem_ready_o,
  output slot_t            slot_data_o,
  output logic             slot_valid_o,
  input  logic             slot_ready_i,
  output logic [CNT_W-1:0] level_o
);
  slot_t            head, push_data;
  logic [CNT_W-1:0] push_len;
  logic             push, pop;

  assign push_data = packed_i ? mem_data_i : (mem_data_i & low_mask(w_i));
  assign push_len  = packed_i ? CNT_W'(SLOT_W) : CNT_W'(w_i);

  // room for a whole word keeps ready off the slot_ready path
  assign mem_ready_o  = level_o <= CNT_W'(BUF_W - SLOT_W);
  assign push         = mem_valid_i && mem_ready_o;
  assign slot_valid_o = level_o >= CNT_W'(w_i);
  assign pop          = slot_valid_o && slot_ready_i;
  assign slot_data_o  = align_slot(head & low_mask(w_i), w_i, right_i);

  apu_bitbuf #(.DATA_W(SLOT_W), .BUF_W(BUF_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .push_i     (push),
    .push_data_i(push_data),
    .push_len_i (push_len),
    .pop_i      (pop),
    .pop_len_i  (CNT_W'(w_i)),
    .head_o     (head),
    .level_o    (level_o)
  );
endmodule

// File: rtl/apu_capture.sv
module apu_capture
  import apu_pkg::*;
#(
  parameter  int BUF_W = 3 * SLOT_W,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  wid_t             w_i,
  input  logic             right_i,
  input  logic             packed_i,
  input  logic             flush_i,
  input  slot_t            slot_data_i,
  input  logic             slot_valid_i,
  output logic             slot_ready_o,
  output slot_t            mem_data_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [CNT_W-1:0] level_o
);
  slot_t            sample, push_data, head;
  logic [CNT_W-1:0] push_len, pop_len;
  logic             push, pop, full, flush_q, flush_done;

  assign sample    = extract_sample(slot_data_i, w_i, right_i);
  assign push_data = packed_i ? sample : align_slot(sample, w_i, 1'b1);
  assign push_len  = packed_i ? CNT_W'(w_i) : CNT_W'(SLOT_W);

  // input frozen while a flush drains so the partial word is final
  assign slot_ready_o = (level_o <= CNT_W'(BUF_W - SLOT_W)) && !flush_q;
  assign push         = slot_valid_i && slot_ready_o;

  assign full        = level_o >= CNT_W'(SLOT_W);
  assign mem_valid_o = full || (flush_q && level_o != '0);
  assign pop         = mem_valid_o && mem_ready_i;
  assign pop_len     = full ? CNT_W'(SLOT_W) : level_o;
  assign mem_data_o  = head;

  assign flush_done = (level_o == '0) || (pop && level_o <= CNT_W'(SLOT_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flush_q <= 1'b0;
    else if (clear_i) flush_q <= 1'b0;
    else              flush_q <= flush_i || (flush_q && !flush_done);
  end

  apu_bitbuf #(.DATA_W(SLOT_W), .BUF_W(BUF_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .push_i     (push),
    .push_data_i(push_data),
    .push_len_i (push_len),
    .pop_i      (pop),
    .pop_len_i  (pop_len),
    .head_o     (head),
    .level_o    (level_o)
  );
endmodule

// File: rtl/audio_align_pack.sv
module audio_align_pack
  import apu_pkg::*;
#(
  parameter  int BUF_WORDS = 3,
  localparam int BUF_W     = BUF_WORDS * SLOT_W,
  localparam int CNT_W     = $clog2(BUF_W + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic [2:0]  width_sel_i,
  input  logic        right_just_i,
  input  logic        packed_i,
  input  logic        flush_i,
  input  logic [31:0] pb_mem_data_i,
  input  logic        pb_mem_valid_i,
  output logic        pb_mem_ready_o,
  output logic [31:0] pb_slot_data_o,
  output logic        pb_slot_valid_o,
  input  logic        pb_slot_ready_i,
  input  logic [31:0] cap_slot_data_i,
  input  logic        cap_slot_valid_i,
  output logic        cap_slot_ready_o,
  output logic [31:0] cap_mem_data_o,
  output logic        cap_mem_valid_o,
  input  logic        cap_mem_ready_i
);
  wid_t             w;
  logic [CNT_W-1:0] pb_level, cap_level;

  assign w = width_bits(width_sel_i);

  apu_playback #(.BUF_W(BUF_W)) u_pb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .w_i         (w),
    .right_i     (right_just_i),
    .packed_i    (packed_i),
    .mem_data_i  (pb_mem_data_i),
    .mem_valid_i (pb_mem_valid_i),
    .mem_ready_o (pb_mem_ready_o),
    .slot_data_o (pb_slot_data_o),
    .slot_valid_o(pb_slot_valid_o),
    .slot_ready_i(pb_slot_ready_i),
    .level_o     (pb_level)
  );

  apu_capture #(.BUF_W(BUF_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .w_i         (w),
    .right_i     (right_just_i),
    .packed_i    (packed_i),
    .flush_i     (flush_i),
    .slot_data_i (cap_slot_data_i),
    .slot_valid_i(cap_slot_valid_i),
    .slot_ready_o(cap_slot_ready_o),
    .mem_data_o  (cap_mem_data_o),
    .mem_valid_o (cap_mem_valid_o),
    .mem_ready_i (cap_mem_ready_i),
    .level_o     (cap_level)
  );
endmodule

// File: rtl/apu_checker.sv
module apu_checker #(
  parameter int LEVEL_W   = 7,
  parameter int LEVEL_MAX = 96
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic               pb_slot_valid_i,
  input logic               pb_slot_ready_i,
  input logic [31:0]        pb_slot_data_i,
  input logic               pb_mem_ready_i,
  input logic               cap_mem_valid_i,
  input logic               cap_mem_ready_i,
  input logic [31:0]        cap_mem_data_i,
  input logic               cap_slot_ready_i,
  input logic [LEVEL_W-1:0] pb_level_i,
  input logic [LEVEL_W-1:0] cap_level_i
);
  p_pb_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_slot_valid_i && !pb_slot_ready_i && !clear_i |=> pb_slot_valid_i && $stable(pb_slot_data_i));

  p_cap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mem_valid_i && !cap_mem_ready_i && !clear_i |=> cap_mem_valid_i && $stable(cap_mem_data_i));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_level_i <= LEVEL_W'(LEVEL_MAX) && cap_level_i <= LEVEL_W'(LEVEL_MAX));

  p_clear_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> pb_level_i == '0 && cap_level_i == '0 && !pb_slot_valid_i && !cap_mem_valid_i
                && pb_mem_ready_i && cap_slot_ready_i);

  p_pb_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_slot_valid_i |-> pb_level_i >= LEVEL_W'(8));
endmodule

bind audio_align_pack apu_checker #(.LEVEL_W(CNT_W), .LEVEL_MAX(BUF_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .clear_i         (clear_i),
  .pb_slot_valid_i (pb_slot_valid_o),
  .pb_slot_ready_i (pb_slot_ready_i),
  .pb_slot_data_i  (pb_slot_data_o),
  .pb_mem_ready_i  (pb_mem_ready_o),
  .cap_mem_valid_i (cap_mem_valid_o),
  .cap_mem_ready_i (cap_mem_ready_i),
  .cap_mem_data_i  (cap_mem_data_o),
  .cap_slot_ready_i(cap_slot_ready_o),
  .pb_level_i      (pb_level),
  .cap_level_i     (cap_level)
);

// File: tb/tb_audio_align_pack.sv
`timescale 1ns/1ps
module tb_audio_align_pack;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic [2:0]  width_sel_i = 3'd0;
  logic        right_just_i = 1'b0;
  logic        packed_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] pb_mem_data_i = '0;
  logic        pb_mem_valid_i = 1'b0;
  logic        pb_mem_ready_o;
  logic [31:0] pb_slot_data_o;
  logic        pb_slot_valid_o;
  logic        pb_slot_ready_i = 1'b0;
  logic [31:0] cap_slot_data_i = '0;
  logic        cap_slot_valid_i = 1'b0;
  logic        cap_slot_ready_o;
  logic [31:0] cap_mem_data_o;
  logic        cap_mem_valid_o;
  logic        cap_mem_ready_i = 1'b0;

  audio_align_pack dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int w_cur = 8;
  bit r_cur = 0, p_cur = 0;
  bit stop_src = 0;
  int src_rate = 100, snk_rate = 100;
  int pb_out_cnt = 0, cap_in_cnt = 0, cap_out_cnt = 0;
  bit pb_q[$];
  bit cap_q[$];
  bit pb_in_f, pb_out_f, cap_in_f, cap_out_f;

  function automatic int f_w(logic [2:0] s);
    case (s)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 18;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] f_align(logic [31:0] s, int w, bit r);
    logic [31:0] o = '0;
    for (int i = 0; i < 32; i++) begin
      if (r) o[i] = (i < w) ? s[i] : s[w-1];
      else   o[i] = (i >= 32 - w) ? s[i-(32-w)] : 1'b0;
    end
    return o;
  endfunction

  function automatic logic [31:0] f_extract(logic [31:0] c, int w, bit r);
    logic [31:0] o = '0;
    for (int i = 0; i < w; i++) o[i] = r ? c[i] : c[i+32-w];
    return o;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (w=%0d right=%0d packed=%0d)",
               req, act, exp, w_cur, r_cur, p_cur);
    end
  endtask

  task automatic step();
    logic [31:0] s, e;
    int n;
    @(negedge clk_i);
    pb_in_f   = pb_mem_valid_i && pb_mem_ready_o;
    pb_out_f  = pb_slot_valid_o && pb_slot_ready_i;
    cap_in_f  = cap_slot_valid_i && cap_slot_ready_o;
    cap_out_f = cap_mem_valid_o && cap_mem_ready_i;
    if (pb_out_f) begin
      pb_out_cnt++;
      if (pb_q.size() < w_cur) begin
        check(0, "R9 playback extra slot", pb_slot_data_o, '0);
      end else begin
        s = '0;
        for (int i = 0; i < w_cur; i++) s[i] = pb_q.pop_front();
        e = f_align(s, w_cur, r_cur);
        check(pb_slot_data_o == e, {p_cur ? "R4" : "R1", r_cur ? " R2" : " R3"}, pb_slot_data_o, e);
      end
    end
    if (cap_out_f) begin
      cap_out_cnt++;
      n = (cap_q.size() < 32) ? cap_q.size() : 32;
      if (n == 0) begin
        check(0, "R7 capture extra word", cap_mem_data_o, '0);
      end else begin
        e = '0;
        for (int i = 0; i < n; i++) e[i] = cap_q.pop_front();
        check(cap_mem_data_o == e, p_cur ? ((n < 32) ? "R7" : "R6") : "R5", cap_mem_data_o, e);
      end
    end
    if (pb_in_f) begin
      n = p_cur ? 32 : w_cur;
      for (int i = 0; i < n; i++) pb_q.push_back(pb_mem_data_i[i]);
    end
    if (cap_in_f) begin
      cap_in_cnt++;
      s = f_extract(cap_slot_data_i, w_cur, r_cur);
      if (p_cur) for (int i = 0; i < w_cur; i++) cap_q.push_back(s[i]);
      else begin
        e = f_align(s, w_cur, 1'b1);
        for (int i = 0; i < 32; i++) cap_q.push_back(e[i]);
      end
    end
    @(posedge clk_i);
    #1;
    if (pb_in_f || !pb_mem_valid_i) begin
      pb_mem_valid_i = !stop_src && (($urandom % 100) < src_rate);
      pb_mem_data_i  = $urandom;
    end
    if (cap_in_f || !cap_slot_valid_i) begin
      cap_slot_valid_i = !stop_src && (($urandom % 100) < src_rate);
      cap_slot_data_i  = $urandom;
    end
    pb_slot_ready_i = ($urandom % 100) < snk_rate;
    cap_mem_ready_i = ($urandom % 100) < snk_rate;
  endtask

  task automatic set_cfg(logic [2:0] sel, bit r, bit p);
    width_sel_i = sel; right_just_i = r; packed_i = p;
    w_cur = f_w(sel); r_cur = r; p_cur = p;
  endtask

  task automatic finish_phase();
    stop_src = 1;
    while (pb_mem_valid_i || cap_slot_valid_i) step();
    flush_i = 1'b1;
    step();
    flush_i = 1'b0;
    repeat (80) step();
    check(pb_q.size() < w_cur, "R9 playback drained", pb_q.size(), w_cur);
    check(cap_q.size() == 0, "R7 flush emptied capture", cap_q.size(), 0);
    clear_i = 1'b1;
    step();
    clear_i = 1'b0;
    pb_q.delete();
    cap_q.delete();
    @(negedge clk_i);
    check(!pb_slot_valid_o && !cap_mem_valid_o && pb_mem_ready_o && cap_slot_ready_o,
          "R10 clear idle", {pb_slot_valid_o, cap_mem_valid_o, pb_mem_ready_o, cap_slot_ready_o}, 32'h3);
    stop_src = 0;
  endtask

  task automatic run_phase(logic [2:0] sel, bit r, bit p, int cycles);
    set_cfg(sel, r, p);
    src_rate = 40 + ($urandom % 61);
    snk_rate = 40 + ($urandom % 61);
    repeat (cycles) step();
    finish_phase();
  endtask

  task automatic bubble_phase(logic [2:0] sel, bit r, bit p);
    set_cfg(sel, r, p);
    src_rate = 100; snk_rate = 100;
    repeat (6) step();
    pb_out_cnt = 0; cap_in_cnt = 0;
    repeat (40) step();
    check(pb_out_cnt == 40, "R8 playback every cycle", pb_out_cnt, 40);
    check(cap_in_cnt == 40, "R8 capture every cycle", cap_in_cnt, 40);
    finish_phase();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(pb_mem_ready_o && !pb_slot_valid_o && cap_slot_ready_o && !cap_mem_valid_o,
          "R10 reset state", {pb_mem_ready_o, pb_slot_valid_o, cap_slot_ready_o, cap_mem_valid_o}, 32'ha);

    // directed: flush with nothing held
    set_cfg(3'd3, 1'b1, 1'b1);
    cap_out_cnt = 0;
    stop_src = 1;
    flush_i = 1'b1;
    step();
    flush_i = 1'b0;
    repeat (6) step();
    check(cap_out_cnt == 0, "R7 empty flush", cap_out_cnt, 0);
    stop_src = 0;

    bubble_phase(3'd4, 1'b1, 1'b1);
    bubble_phase(3'd0, 1'b0, 1'b0);
    bubble_phase(3'd2, 1'b0, 1'b1);

    for (int sel = 0; sel < 8; sel++)
      for (int p = 0; p < 2; p++)
        run_phase(3'(sel), 1'($urandom % 2), 1'(p), 200);
    for (int k = 0; k < 8; k++)
      run_phase(3'($urandom % 6), 1'($urandom % 2), 1'($urandom % 2), 300);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule